// File: doc/BRIEF.md
# Programmable Logic Cell

A behavioural model of one configurable logic cell as found in a field-programmable array. Four data inputs address a 16-entry truth table. The result can go straight to the two cell outputs, or it can be captured in a flip-flop first. That flip-flop has a selectable clock, a clock enable, and an asynchronous clear and preset. The clear and preset are driven from two local clear pins and a chip-wide reset, and configuration decides which of these sources act.

An arithmetic mode turns the cell into a one-bit adder stage. Operand X is data input 0 and operand Y is the truth-table output, so a suitable table gives add, subtract or pass. The cell then takes a carry from its lower neighbour and produces a carry for the next cell. All configuration comes in on a static vector, `cfgBits`, which stands in for the programming memory. The vector is meant to change only while the cell is idle. The field layout is:

- `cfgBits[15:0]` truth table
- bit 16 bypass
- bit 17 clock select
- bit 18 enable clear A
- bit 19 enable clear B
- bit 20 clear B acts as preset
- bit 21 arithmetic mode
- bit 22 enable chip reset

Top module: `lcell_top`

## Requirements
- R1: The lookup value is `cfgBits[{dataIn[3],dataIn[2],dataIn[1],dataIn[0]}]`, with `dataIn[3]` as the most significant index bit.
- R2: With bypass (bit 16) set, `rowOut` and `localOut` both follow the cell value combinationally, with no clock needed.
- R3: With bypass clear, `rowOut` and `localOut` both show the flip-flop. The flip-flop loads the cell value on a rising edge of the selected clock when `clkEn` is 1.
- R4: Clock select (bit 17) = 0 picks `clkA` and = 1 picks `clkB`. Edges on the clock that is not selected leave the flip-flop unchanged.
- R5: With `clkEn` = 0, a rising edge of the selected clock leaves the flip-flop unchanged.
- R6: A low level on `clrAN` (if bit 18 is set) or on `clrBN` (if bit 19 is set and bit 20 is clear) clears the flip-flop to 0 at once, without waiting for a clock. A clear pin whose enable bit is 0 has no effect.
- R7: With bits 19 and 20 both set, a low level on `clrBN` presets the flip-flop to 1 at once.
- R8: A low level on `chipRstN` with bit 22 set clears the flip-flop, and is ignored when bit 22 is 0. When clear and preset are requested together, the clear wins.
- R9: With bit 21 set, the cell value is `dataIn[0] ^ lut ^ carryIn` and `carryOut` is the majority of `dataIn[0]`, `lut` and `carryIn`. With bit 21 clear, `carryOut` equals `carryIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | First clock candidate |
| clkB | input | 1 | Second clock candidate |
| chipRstN | input | 1 | Chip-wide reset, active low |
| clrAN | input | 1 | Local clear A, active low |
| clrBN | input | 1 | Local clear B, active low |
| cfgBits | input | 23 | Static configuration vector |
| dataIn | input | 4 | Lookup-table address inputs |
| clkEn | input | 1 | Flip-flop clock enable |
| carryIn | input | 1 | Carry from the neighbouring cell |
| carryOut | output | 1 | Carry to the next cell |
| rowOut | output | 1 | Output toward the long interconnect |
| localOut | output | 1 | Output toward the neighbour interconnect |

## Verification
The embedded assertions check on every cycle that clear and preset are never both driven, and that an enabled chip reset always reaches the clear strobe. They also check that an active clear or preset holds the flip-flop at its forced value, and that the flip-flop either loads the sampled value or stays put as `clkEn` dictates. Some behaviours can only be shown by the bench's scenarios. These are the truth-table contents over all 16 addresses under random tables, the bypass versus registered routing, and the fact that edges on the clock that is not selected are ignored. The same holds for clears whose enable bit is 0 and for the adder sum and carry against a reference model.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K = 4;
  localparam int TT_W  = 1 << LUT_K;

  typedef struct packed {
    logic            useChipRst;
    logic            arithMode;
    logic            clrBIsPreset;
    logic            useClrB;
    logic            useClrA;
    logic            clkSel;
    logic            bypass;
    logic [TT_W-1:0] truthTable;
  } cellCfg_t;

  localparam int CFG_W = $bits(cellCfg_t);

  typedef struct packed {
    logic selClk;
    logic clrN;
    logic preN;
  } regStrobe_t;
endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic       clkA,
  input  logic       clkB,
  input  logic       chipRstN,
  input  logic       clrAN,
  input  logic       clrBN,
  input  cellCfg_t   cfg,
  output regStrobe_t strb
);
  logic clearReq;
  logic presetReq;

  always_comb begin
    clearReq  = (cfg.useChipRst & ~chipRstN)
              | (cfg.useClrA & ~clrAN)
              | (cfg.useClrB & ~cfg.clrBIsPreset & ~clrBN);
    presetReq = cfg.useClrB & cfg.clrBIsPreset & ~clrBN;
    strb.selClk = cfg.clkSel ? clkB : clkA;
    strb.clrN   = ~clearReq;
    strb.preN   = ~(presetReq & ~clearReq);
  end

  always_comb begin
    if (!$isunknown({strb.clrN, strb.preN}))
      a_clr_over_pre_r8: assert (strb.clrN || strb.preN);
    if (!$isunknown({chipRstN, cfg.useChipRst, strb.clrN}))
      if (cfg.useChipRst && !chipRstN)
        a_chip_reset_r8: assert (!strb.clrN);
  end
endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
(
  input  regStrobe_t      strb,
  input  logic            chipRstN,
  input  logic [TT_W-1:0] truthTable,
  input  logic            bypass,
  input  logic            arithMode,
  input  logic [LUT_K-1:0] dataIn,
  input  logic            clkEn,
  input  logic            carryIn,
  output logic            carryOut,
  output logic            rowOut,
  output logic            localOut
);
  logic lutOut;
  logic opX;
  logic cellValue;
  logic regQ;
  logic cellOut;

  always_comb begin
    lutOut    = truthTable[dataIn];
    opX       = dataIn[0];
    cellValue = arithMode ? (opX ^ lutOut ^ carryIn) : lutOut;
    carryOut  = arithMode ? ((opX & lutOut) | (opX & carryIn) | (lutOut & carryIn))
                          : carryIn;
  end

  always_ff @(posedge strb.selClk or negedge strb.clrN or negedge strb.preN) begin
    if (!strb.clrN)      regQ <= 1'b0;
    else if (!strb.preN) regQ <= 1'b1;
    else if (clkEn)      regQ <= cellValue;
  end

  assign cellOut  = bypass ? cellValue : regQ;
  assign rowOut   = cellOut;
  assign localOut = cellOut;

  p_clear_holds_r6: assert property (@(posedge strb.selClk) disable iff (!chipRstN)
    !strb.clrN |-> regQ == 1'b0);
  p_preset_holds_r7: assert property (@(posedge strb.selClk) disable iff (!chipRstN)
    (strb.clrN && !strb.preN) |-> regQ == 1'b1);
  p_load_r3: assert property (@(posedge strb.selClk) disable iff (!chipRstN)
    (strb.clrN && strb.preN && $past(strb.clrN && strb.preN && clkEn))
      |-> regQ == $past(cellValue));
  p_hold_r5: assert property (@(posedge strb.selClk) disable iff (!chipRstN)
    (strb.clrN && strb.preN && $past(strb.clrN && strb.preN && !clkEn))
      |-> $stable(regQ));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic              clkA,
  input  logic              clkB,
  input  logic              chipRstN,
  input  logic              clrAN,
  input  logic              clrBN,
  input  logic [CFG_W-1:0]  cfgBits,
  input  logic [LUT_K-1:0]  dataIn,
  input  logic              clkEn,
  input  logic              carryIn,
  output logic              carryOut,
  output logic              rowOut,
  output logic              localOut
);
  cellCfg_t   cfg;
  regStrobe_t strb;

  assign cfg = cellCfg_t'(cfgBits);

  lcell_ctrl i_ctrl (
    .clkA(clkA), .clkB(clkB), .chipRstN(chipRstN),
    .clrAN(clrAN), .clrBN(clrBN), .cfg(cfg), .strb(strb)
  );

  lcell_dp i_dp (
    .strb(strb), .chipRstN(chipRstN), .truthTable(cfg.truthTable),
    .bypass(cfg.bypass), .arithMode(cfg.arithMode), .dataIn(dataIn),
    .clkEn(clkEn), .carryIn(carryIn), .carryOut(carryOut),
    .rowOut(rowOut), .localOut(localOut)
  );
endmodule

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;
  import lcell_pkg::*;

  logic clkA = 0, clkB = 0, chipRstN = 0, clrAN = 1, clrBN = 1;
  logic [CFG_W-1:0] cfgBits = '0;
  logic [LUT_K-1:0] dataIn = '0;
  logic clkEn = 0, carryIn = 0;
  logic carryOut, rowOut, localOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clkA = ~clkA;

  lcell_top i_lcell_top (.*);

  function automatic logic [CFG_W-1:0] mkCfg(logic [15:0] tt, bit byp, bit csel,
      bit uA, bit uB, bit bPre, bit arith, bit uRst);
    return {uRst, arith, bPre, uB, uA, csel, byp, tt};
  endfunction

  function automatic logic lutRef(logic [15:0] tt, logic [3:0] d);
    return tt[d];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic loadReg(logic v);
    @(negedge clkA);
    cfgBits = mkCfg(v ? 16'hFFFF : 16'h0000, 0, 0, 0, 0, 0, 0, 1);
    clkEn = 1;
    @(posedge clkA); #1;
    @(negedge clkA); clkEn = 0;
  endtask

  initial begin
    #500000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CE11));
    // R8 reset state with chip reset enabled
    cfgBits = mkCfg(16'hFFFF, 0, 0, 0, 0, 0, 0, 1);
    clkEn = 1;
    repeat (3) @(posedge clkA);
    #1 chk("R8 reset", rowOut, 1'b0);
    @(negedge clkA); chipRstN = 1; clkEn = 0;

    // R1 R2 bypass, random tables, all addresses
    for (int t = 0; t < 8; t++) begin
      logic [15:0] tt = 16'($urandom);
      cfgBits = mkCfg(tt, 1, 0, 0, 0, 0, 0, 1);
      for (int a = 0; a < 16; a++) begin
        dataIn = 4'(a); #1;
        chk("R1 R2 rowOut", rowOut, lutRef(tt, 4'(a)));
        chk("R2 localOut", localOut, lutRef(tt, 4'(a)));
      end
    end

    // R3 registered mode, random tables
    for (int t = 0; t < 8; t++) begin
      logic [15:0] tt = 16'($urandom);
      for (int a = 0; a < 16; a++) begin
        @(negedge clkA);
        cfgBits = mkCfg(tt, 0, 0, 0, 0, 0, 0, 1);
        dataIn = 4'(a); clkEn = 1;
        @(posedge clkA); #1;
        chk("R3 registered", rowOut, lutRef(tt, 4'(a)));
        chk("R3 local", localOut, lutRef(tt, 4'(a)));
      end
    end

    // R5 clock enable low holds
    loadReg(1);
    @(negedge clkA); cfgBits = mkCfg(16'h0000, 0, 0, 0, 0, 0, 0, 1);
    @(posedge clkA); #1 chk("R5 hold", rowOut, 1'b1);

    // R4 clock select: clkB selected, clkA edges ignored
    @(negedge clkA); cfgBits = mkCfg(16'h0000, 0, 1, 0, 0, 0, 0, 1); clkEn = 1;
    @(posedge clkA); #1 chk("R4 clkA ignored", rowOut, 1'b1);
    @(negedge clkA); clkB = 1; #1 chk("R4 clkB loads", rowOut, 1'b0);
    #2 clkB = 0;
    @(negedge clkA); cfgBits = mkCfg(16'h0000, 0, 0, 0, 0, 0, 0, 1); clkEn = 0;

    // R6 enabled clear A acts at once
    loadReg(1);
    cfgBits = mkCfg(16'hFFFF, 0, 0, 1, 0, 0, 0, 1);
    #1 clrAN = 0; #1 chk("R6 clrA async", rowOut, 1'b0);
    @(posedge clkA); @(negedge clkA); clrAN = 1;
    // R6 disabled clear A ignored
    loadReg(1);
    cfgBits = mkCfg(16'hFFFF, 0, 0, 0, 0, 0, 0, 1);
    #1 clrAN = 0; @(posedge clkA); #1 chk("R6 clrA disabled", rowOut, 1'b1);
    @(negedge clkA); clrAN = 1;
    // R6 clear B as clear
    cfgBits = mkCfg(16'hFFFF, 0, 0, 0, 1, 0, 0, 1);
    #1 clrBN = 0; #1 chk("R6 clrB clear", rowOut, 1'b0);
    @(posedge clkA); @(negedge clkA); clrBN = 1;

    // R7 clear B as preset
    loadReg(0);
    cfgBits = mkCfg(16'h0000, 0, 0, 1, 1, 1, 0, 1);
    #1 clrBN = 0; #1 chk("R7 preset", rowOut, 1'b1);
    // R8 clear wins over preset
    clrAN = 0; #1 chk("R8 clear over preset", rowOut, 1'b0);
    @(posedge clkA); @(negedge clkA); clrAN = 1; clrBN = 1;

    // R8 chip reset ignored when not enabled
    loadReg(1);
    cfgBits = mkCfg(16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    #1 chipRstN = 0; @(posedge clkA); #1 chk("R8 reset disabled", rowOut, 1'b1);
    @(negedge clkA); chipRstN = 1;
    // R8 chip reset enabled clears
    cfgBits = mkCfg(16'hFFFF, 0, 0, 0, 0, 0, 0, 1);
    #1 chipRstN = 0; #1 chk("R8 reset enabled", rowOut, 1'b0);
    @(posedge clkA); @(negedge clkA); chipRstN = 1;

    // R9 arithmetic mode with lut = dataIn[1]
    for (int i = 0; i < 32; i++) begin
      logic [3:0] d = 4'($urandom);
      logic c = 1'($urandom);
      logic s, co;
      cfgBits = mkCfg(16'hCCCC, 1, 0, 0, 0, 0, 1, 1);
      dataIn = d; carryIn = c; #1;
      s  = d[0] ^ d[1] ^ c;
      co = (d[0] & d[1]) | (d[0] & c) | (d[1] & c);
      chk("R9 sum", rowOut, s);
      chk("R9 carry", carryOut, co);
    end
    // R9 normal mode passes carry
    for (int i = 0; i < 4; i++) begin
      cfgBits = mkCfg(16'hCCCC, 1, 0, 0, 0, 0, 0, 1);
      dataIn = 4'(i); carryIn = i[1]; #1;
      chk("R9 carry pass", carryOut, i[1]);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule